// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block turns an offset into a memory-mapped flash region into a device choice. Four flash devices share the region. Each one owns a window whose length comes from its own size register, counted in kilobytes. The windows sit one after another from offset zero, in the fixed order device 0, device 1, device 2, device 3. The start of each window is never programmed. It is the sum of the sizes of all windows below it. A device whose size is zero takes up no space, so the next device up starts where the last non-zero window ended.

A lookup carries an offset and a valid strobe. One clock later the block returns the device index, a one-hot chip-select vector, the address local to that device (the offset minus the window start), and a miss flag. The miss flag is set for any offset at or above the total of all four windows. A simple write port loads the size registers. Every window bound is derived combinationally from the registers, so a change affects the first lookup presented after the write edge.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset every size register holds zero. `rsp_valid`, `rsp_cs`, `rsp_sel`, `rsp_local` and `rsp_miss` are all zero, and any lookup made before a size is written misses.
- R2: A write with `cfg_we` high and `cfg_addr` equal to 0x60 + 4*k (k = 0..3) loads `cfg_wdata[SIZE_W-1:0]` into the size register of device k. Data bits above `SIZE_W` are ignored. A write to any other address changes no size register.
- R3: The windows are contiguous and are laid out in ascending device order 0, 1, 2, 3, starting at offset 0. The window of device k covers [base_k, base_k + size_k*1024), where base_k is the sum of size_j*1024 over all j < k.
- R4: On a hit, `rsp_local` equals the lookup offset minus base_k of the selected device k.
- R5: A device whose size register is zero is never selected, and the window above it starts at the same base.
- R6: An offset at or above the sum of all four window sizes sets `rsp_miss`. It also sets `rsp_cs` to zero, `rsp_sel` to 0 and `rsp_local` to 0.
- R7: The response to a lookup presented at clock edge t appears on the outputs just after edge t. `rsp_valid` is high exactly in the cycles that follow an edge at which `req_valid` was high. While `req_valid` is low, the data outputs hold their values.
- R8: When only one size register is non-zero, that device covers the whole range [0, size*1024), and its local address equals the offset.
- R9: A lookup presented at the same edge as a size write is decoded with the old sizes. A lookup presented at the next edge uses the new sizes.
- R10: On a hit, `rsp_cs` is one-hot, and its set bit is at position `rsp_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Size register write strobe |
| cfg_addr | input | CFG_AW (8) | Byte address of the register written |
| cfg_wdata | input | CFG_DW (32) | Write data; low SIZE_W bits hold the size in KB |
| req_valid | input | 1 | Lookup strobe |
| req_offset | input | OFS_W (32) | Offset into the mapped region |
| rsp_valid | output | 1 | Response for the lookup of the previous edge |
| rsp_cs | output | NUM_DEV (4) | One-hot chip select, zero on miss |
| rsp_sel | output | SEL_W (2) | Index of the selected device |
| rsp_local | output | OFS_W (32) | Offset local to the selected device |
| rsp_miss | output | 1 | Offset lies beyond all windows |

## Verification
The assertions assume that the sum of the four window sizes in bytes fits in `OFS_W` bits. If it does not, the upper bounds wrap around, and both the disjointness check and the miss-versus-total check lose their meaning. The bench keeps every size at or below a few hundred kilobytes against a 32-bit offset, so no bound comes near wrapping. It also keeps random offsets within a small margin above the total, so that both hits and misses are exercised. Register writes are only made through the port, with the bench tracking which addresses are valid slots. The write-stability assertion therefore sees every real update.

// File: rtl/cs_window_pkg.sv
package cs_window_pkg;
  localparam int unsigned WIN_REG_BASE   = 'h60;
  localparam int unsigned WIN_REG_STRIDE = 4;
  localparam int unsigned KB_SHIFT       = 10;
endpackage

// File: rtl/cs_window_sizes.sv
module cs_window_sizes
  import cs_window_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int SIZE_W  = 18,
  parameter int OFS_W   = 32,
  parameter int CFG_AW  = 8,
  parameter int CFG_DW  = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [CFG_DW-1:0]               cfg_wdata,
  output logic [NUM_DEV-1:0][OFS_W-1:0]   win_lo,
  output logic [NUM_DEV-1:0][OFS_W-1:0]   win_hi
);
  logic [NUM_DEV-1:0][SIZE_W-1:0] size_kb;
  logic [NUM_DEV-1:0][OFS_W-1:0]  size_bytes;

  // Upper data bits carry nothing (R2)
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^cfg_wdata[CFG_DW-1:SIZE_W];

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_slot
    localparam logic [CFG_AW-1:0] SLOT_ADDR = CFG_AW'(WIN_REG_BASE + k * WIN_REG_STRIDE);
    logic slot_hit;
    assign slot_hit = cfg_we && (cfg_addr == SLOT_ADDR);

    always_ff @(posedge clk) begin
      if (rst) size_kb[k] <= '0;
      else if (slot_hit) size_kb[k] <= cfg_wdata[SIZE_W-1:0];
    end

    assign size_bytes[k] = OFS_W'(size_kb[k]) << KB_SHIFT;

    if (k == 0) begin : g_first
      assign win_lo[k] = '0;
    end else begin : g_rest
      assign win_lo[k] = win_hi[k-1];
    end
    assign win_hi[k] = win_lo[k] + size_bytes[k];

    // R2: a size register moves only on a write to its own slot
    assert_slot_stable_R2: assert property (@(posedge clk) disable iff (rst)
      !(cfg_we && cfg_addr == SLOT_ADDR) |=> $stable(size_kb[k]));
  end
endmodule

// File: rtl/cs_window_match.sv
module cs_window_match #(
  parameter int NUM_DEV = 4,
  parameter int OFS_W   = 32,
  parameter int SEL_W   = $clog2(NUM_DEV)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [OFS_W-1:0]              req_offset,
  input  logic [NUM_DEV-1:0][OFS_W-1:0] win_lo,
  input  logic [NUM_DEV-1:0][OFS_W-1:0] win_hi,
  output logic                          rsp_valid,
  output logic [NUM_DEV-1:0]            rsp_cs,
  output logic [SEL_W-1:0]              rsp_sel,
  output logic [OFS_W-1:0]              rsp_local,
  output logic                          rsp_miss
);
  logic [NUM_DEV-1:0] hit_vec;
  logic [SEL_W-1:0]   sel_c;
  logic [OFS_W-1:0]   base_c;
  logic               miss_c;

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_cmp
    assign hit_vec[k] = (req_offset >= win_lo[k]) && (req_offset < win_hi[k]);

    // R5: an empty window can never claim an offset
    assert_empty_unsel_R5: assert property (@(posedge clk) disable iff (rst)
      (req_valid && win_lo[k] == win_hi[k]) |-> !hit_vec[k]);
  end

  always_comb begin
    sel_c  = '0;
    base_c = '0;
    for (int k = 0; k < NUM_DEV; k++) begin
      if (hit_vec[k]) begin
        sel_c  = SEL_W'(k);
        base_c = win_lo[k];
      end
    end
  end

  assign miss_c = ~|hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_cs    <= '0;
      rsp_sel   <= '0;
      rsp_local <= '0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cs    <= hit_vec;
        rsp_sel   <= sel_c;
        rsp_local <= miss_c ? '0 : (req_offset - base_c);
        rsp_miss  <= miss_c;
      end
    end
  end

  // R3: windows never overlap
  assert_disjoint_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $onehot0(hit_vec));
  // R6: miss coincides with an offset past the top of the stack
  assert_miss_total_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (miss_c == (req_offset >= win_hi[NUM_DEV-1])));
  // R6: a miss drives no chip select and a zero local address
  assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_miss) |-> (rsp_cs == '0 && rsp_local == '0 && rsp_sel == '0));
  // R10: a hit asserts exactly the chip select named by the index
  assert_cs_match_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_miss) |-> ($onehot0(rsp_cs) && rsp_cs[rsp_sel]));
  // R7: one-cycle response timing
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_local) && $stable(rsp_cs)));
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder #(
  parameter int NUM_DEV = 4,
  parameter int SIZE_W  = 18,
  parameter int OFS_W   = 32,
  parameter int CFG_AW  = 8,
  parameter int CFG_DW  = 32,
  localparam int SEL_W  = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic               req_valid,
  input  logic [OFS_W-1:0]   req_offset,
  output logic               rsp_valid,
  output logic [NUM_DEV-1:0] rsp_cs,
  output logic [SEL_W-1:0]   rsp_sel,
  output logic [OFS_W-1:0]   rsp_local,
  output logic               rsp_miss
);
  logic [NUM_DEV-1:0][OFS_W-1:0] win_lo;
  logic [NUM_DEV-1:0][OFS_W-1:0] win_hi;

  cs_window_sizes #(
    .NUM_DEV(NUM_DEV), .SIZE_W(SIZE_W), .OFS_W(OFS_W),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) i_sizes (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_lo(win_lo), .win_hi(win_hi)
  );

  cs_window_match #(
    .NUM_DEV(NUM_DEV), .OFS_W(OFS_W), .SEL_W(SEL_W)
  ) i_match (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_offset(req_offset),
    .win_lo(win_lo), .win_hi(win_hi), .rsp_valid(rsp_valid), .rsp_cs(rsp_cs),
    .rsp_sel(rsp_sel), .rsp_local(rsp_local), .rsp_miss(rsp_miss)
  );
endmodule

// File: tb/test_cs_window_decoder.sv
`timescale 1ns/1ps
module test_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_offset = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_cs;
  logic [1:0]  rsp_sel;
  logic [31:0] rsp_local;
  logic        rsp_miss;

  int checks = 0;
  int errors = 0;

  // Reference model state
  longint unsigned msize[4];
  bit              e_valid = 0;
  logic [3:0]      e_cs = '0;
  logic [1:0]      e_sel = '0;
  logic [31:0]     e_local = '0;
  bit              e_miss = 0;
  string           e_tag = "R1";

  always #2.5 clk = ~clk;

  cs_window_decoder i_cs_window_decoder (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_cs(rsp_cs),
    .rsp_sel(rsp_sel), .rsp_local(rsp_local), .rsp_miss(rsp_miss)
  );

  task automatic compare();
    bit bad;
    checks++;
    bad = (rsp_valid !== e_valid);
    if (e_valid)
      bad = bad || (rsp_cs !== e_cs) || (rsp_sel !== e_sel) ||
            (rsp_local !== e_local) || (rsp_miss !== e_miss);
    if (bad) begin
      errors++;
      $display("FAIL %s: got v=%0b cs=%b sel=%0d local=%0h miss=%0b, expected v=%0b cs=%b sel=%0d local=%0h miss=%0b",
               e_tag, rsp_valid, rsp_cs, rsp_sel, rsp_local, rsp_miss,
               e_valid, e_cs, e_sel, e_local, e_miss);
    end
  endtask

  // One clock: check the previous response, drive new inputs, predict, update model.
  task automatic cyc(bit we, logic [7:0] a, logic [31:0] d, bit v, logic [31:0] off, string tag);
    longint unsigned base;
    compare();
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    req_valid = v; req_offset = off;
    e_valid = v;
    e_tag = tag;
    if (v) begin
      e_cs = '0; e_sel = '0; e_local = '0; e_miss = 1;
      base = 0;
      for (int k = 0; k < 4; k++) begin
        if (e_miss && off >= base && off < base + (msize[k] << 10)) begin
          e_miss = 0;
          e_cs = 4'(1 << k);
          e_sel = 2'(k);
          e_local = 32'(off - base);
        end
        base += msize[k] << 10;
      end
    end
    if (we && a >= 8'h60 && a <= 8'h6C && a[1:0] == 2'b00)
      msize[(a - 8'h60) >> 2] = longint'(d & 32'h0003_FFFF);
    @(negedge clk);
  endtask

  task automatic look(logic [31:0] off, string tag);
    cyc(0, 8'h00, 32'h0, 1, off, tag);
  endtask

  task automatic wr(int k, logic [31:0] d);
    cyc(1, 8'(8'h60 + 4 * k), d, 0, 32'h0, "R2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) msize[k] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (rsp_valid !== 0 || rsp_cs !== 0 || rsp_sel !== 0 || rsp_local !== 0 || rsp_miss !== 0) begin
      errors++;
      $display("FAIL R1: got v=%0b cs=%b sel=%0d local=%0h miss=%0b, expected all zero",
               rsp_valid, rsp_cs, rsp_sel, rsp_local, rsp_miss);
    end
    look(32'h0, "R1");            // all sizes zero -> miss
    look(32'h10, "R1");
    // R8: only device 2 populated
    wr(2, 32'd64);
    look(32'h0, "R8");
    look(32'hFFFF, "R8");
    look(32'h1_0000, "R6");
    // R2: stray and misaligned addresses ignored
    cyc(1, 8'h70, 32'd5, 0, 32'h0, "R2");
    cyc(1, 8'h61, 32'd5, 0, 32'h0, "R2");
    cyc(1, 8'h5C, 32'd5, 0, 32'h0, "R2");
    look(32'h0, "R2");
    look(32'hFFFF, "R2");
    // R2: upper data bits dropped -> size 2 KB on device 0
    wr(0, 32'hFFFC_0002);
    look(32'h7FF, "R2");
    look(32'h800, "R2");
    // R3/R4/R5: sizes 4, 8, 0, 16 KB
    wr(0, 32'd4); wr(1, 32'd8); wr(2, 32'd0); wr(3, 32'd16);
    look(32'd0, "R3");
    look(32'd4095, "R4");
    look(32'd4096, "R4");
    look(32'd12287, "R3");
    look(32'd12288, "R5");
    look(32'd28671, "R4");
    look(32'd28672, "R6");
    look(32'hFFFF_FFFF, "R6");
    // R9: write and lookup at the same edge use the old size
    cyc(1, 8'h60, 32'd1, 1, 32'd2048, "R9");
    look(32'd2048, "R9");
    // R7: idle gap then back-to-back lookups
    cyc(0, 8'h00, 32'h0, 0, 32'd0, "R7");
    cyc(0, 8'h00, 32'h0, 0, 32'd0, "R7");
    look(32'd100, "R7");
    look(32'd5000, "R7");
    // R10/R3/R4: random sizes and offsets
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < 4; k++)
        wr(k, ($urandom_range(0, 3) == 0) ? 32'd0 : 32'($urandom_range(1, 300)));
      for (int m = 0; m < 20; m++) begin
        longint unsigned tot;
        tot = (msize[0] + msize[1] + msize[2] + msize[3]) << 10;
        look(32'($urandom_range(0, 32'(tot) + 2048)), "R10");
      end
    end
    cyc(0, 8'h00, 32'h0, 0, 32'h0, "R7");
    compare();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule